// File: doc/BRIEF.md
# Machine-Check Bank Error Logger

This block holds an array of error-reporting banks for machine-check handling, each with a control word, a status word, an address word and a misc word, plus one global status word. A single injection port presents a candidate error: the bank number, the new status, the global status to install, the address, the misc data and a flag that forces an action-optional error through. The block checks the request, then applies the logging rules. Whether an entry is overwritten, only marked as overflowed, dropped or escalated depends on whether the new error and the error already in the bank are uncorrected, and on whether a machine check is already in progress.

Each injection produces exactly one outcome code on the cycle after the strobe. The outcome may be accompanied by a one-cycle interrupt pulse (an uncorrected error was logged) or a one-cycle reset request (an uncorrected error could not be delivered). The capability word, the global control word and the machine-check enable are static inputs from the surrounding core. A small configuration write port loads bank control, bank status and global status. A combinational read port returns one bank's registers.

Top module: `mce_bank_log`

## Requirements
- R1: After reset every bank status, address and misc word is zero, every bank control word is all ones, the global status is zero and out_valid_o, irq_o and reset_req_o are low.
- R2: An injection is rejected (code 0) with no register change when cap_i is zero, when the bank number is not below cap_i[7:0], when the bank number is not below NB, or when status bit 63 (valid) is clear.
- R3: An injection whose status bit 55 (action required) is clear, made while global status bit 2 (in progress) is set and inj_uncond_i is low, is ignored (code 1) with no register change; with inj_uncond_i high it is processed normally.
- R4: An uncorrected injection (status bit 61 set) is dropped (code 2) with no register change when cap_i[8] is set and gctl_i is not all ones, or when the target bank's control word is not all ones.
- R5: An uncorrected injection that is not dropped requests a reset (code 3, one reset_req_o pulse, no register change) when mce_en_i is low or global status bit 2 is set.
- R6: Otherwise an uncorrected injection is logged (code 4). The bank takes the new address, the new misc and the new status, with bit 62 (overflow) forced on if the bank held a valid entry. The global status takes inj_gstat_i, and irq_o pulses once.
- R7: A corrected injection (bit 61 clear) into a bank that is empty or holds a corrected entry is logged (code 4) as in R6, but the global status is left unchanged and irq_o stays low.
- R8: A corrected injection into a bank holding a valid uncorrected entry only sets bit 62 of that entry (code 5); address and misc are kept.
- R9: out_valid_o is high for exactly the one cycle after each inj_valid_i cycle, with out_code_o in the range 0 to 5.
- R10: A configuration write with cfg_sel_i 0 loads the bank control word, 1 loads the bank status word, and 2 loads the global status. The read port returns the selected bank's words, or zero for a bank number not below NB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 16 | Capability: [7:0] bank count, [8] global control present |
| gctl_i | input | W | Global control word |
| mce_en_i | input | 1 | Machine-check delivery enabled |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | 0 bank control, 1 bank status, 2 global status |
| cfg_bank_i | input | 8 | Bank for a configuration write |
| cfg_data_i | input | W | Configuration write data |
| inj_valid_i | input | 1 | Injection strobe |
| inj_bank_i | input | 8 | Target bank |
| inj_status_i | input | W | New bank status |
| inj_gstat_i | input | W | Global status installed on an uncorrected log |
| inj_addr_i | input | W | New address word |
| inj_misc_i | input | W | New misc word |
| inj_uncond_i | input | 1 | Process action-optional errors even while a check is in progress |
| rd_bank_i | input | 8 | Bank selected on the read port |
| rd_ctl_o | output | W | Selected bank control word |
| rd_status_o | output | W | Selected bank status word |
| rd_addr_o | output | W | Selected bank address word |
| rd_misc_o | output | W | Selected bank misc word |
| gstat_o | output | W | Global status |
| out_valid_o | output | 1 | Outcome valid |
| out_code_o | output | 3 | 0 rejected, 1 ignored, 2 dropped, 3 reset, 4 logged, 5 overflow only |
| irq_o | output | 1 | Machine-check interrupt pulse |
| reset_req_o | output | 1 | Reset request pulse |

## Verification
The bench targets the ordering of the decisions. An action-required uncorrected error arriving during a check in progress must escalate to reset rather than be ignored. A disabled bank control must drop an error even when the enable is off. A design with those checks in the wrong order would give the wrong code and either touch the bank or raise a spurious pulse. The bench also covers a corrected error landing on an uncorrected entry, where a faulty design would overwrite the address and misc instead of only marking overflow. It checks the overflow bit set on overwriting a valid entry, and that the global status is replaced only for uncorrected logging. A long random phase covers the rejection limits of both the capability count and the physical bank count.

// File: rtl/mce_bank_log.sv
module mce_bank_log #(
  parameter int NB = 4,
  parameter int W  = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  cap_i,
  input  logic [W-1:0] gctl_i,
  input  logic         mce_en_i,
  input  logic         cfg_we_i,
  input  logic [1:0]   cfg_sel_i,
  input  logic [7:0]   cfg_bank_i,
  input  logic [W-1:0] cfg_data_i,
  input  logic         inj_valid_i,
  input  logic [7:0]   inj_bank_i,
  input  logic [W-1:0] inj_status_i,
  input  logic [W-1:0] inj_gstat_i,
  input  logic [W-1:0] inj_addr_i,
  input  logic [W-1:0] inj_misc_i,
  input  logic         inj_uncond_i,
  input  logic [7:0]   rd_bank_i,
  output logic [W-1:0] rd_ctl_o,
  output logic [W-1:0] rd_status_o,
  output logic [W-1:0] rd_addr_o,
  output logic [W-1:0] rd_misc_o,
  output logic [W-1:0] gstat_o,
  output logic         out_valid_o,
  output logic [2:0]   out_code_o,
  output logic         irq_o,
  output logic         reset_req_o
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [7:0] NB8 = 8'(NB);
  localparam int B_VAL = W - 1;
  localparam int B_OVR = W - 2;
  localparam int B_UC  = W - 3;
  localparam int B_AR  = W - 9;
  localparam int B_MCIP = 2;
  localparam logic [2:0] C_REJ = 3'd0, C_IGN = 3'd1, C_DROP = 3'd2,
                         C_RST = 3'd3, C_LOG = 3'd4, C_OVF = 3'd5;

  logic [NB-1:0][W-1:0] ctl_q, st_q, ad_q, mi_q;
  logic [W-1:0] gs_q, old_st, new_st;
  logic [2:0] code_d;
  logic [BW-1:0] ib, cb, rb;

  assign ib = inj_bank_i[BW-1:0];
  assign cb = cfg_bank_i[BW-1:0];
  assign rb = rd_bank_i[BW-1:0];

  wire bank_ok = (inj_bank_i < cap_i[7:0]) && (inj_bank_i < NB8);
  wire is_uc   = inj_status_i[B_UC];
  wire mcip    = gs_q[B_MCIP];
  assign old_st = st_q[ib];

  always_comb begin
    new_st = inj_status_i;
    if (old_st[B_VAL]) new_st[B_OVR] = 1'b1;
    if (cap_i == 16'd0 || !bank_ok || !inj_status_i[B_VAL])
      code_d = C_REJ;
    else if (!inj_uncond_i && !inj_status_i[B_AR] && mcip)
      code_d = C_IGN;
    else if (is_uc) begin
      if ((cap_i[8] && !(&gctl_i)) || !(&ctl_q[ib])) code_d = C_DROP;
      else if (!mce_en_i || mcip)                       code_d = C_RST;
      else                                              code_d = C_LOG;
    end else if (!old_st[B_VAL] || !old_st[B_UC])
      code_d = C_LOG;
    else
      code_d = C_OVF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '1;
      st_q <= '0;
      ad_q <= '0;
      mi_q <= '0;
      gs_q <= '0;
      out_valid_o <= 1'b0;
      out_code_o <= C_REJ;
      irq_o <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      out_valid_o <= inj_valid_i;
      out_code_o  <= inj_valid_i ? code_d : C_REJ;
      irq_o       <= inj_valid_i && code_d == C_LOG && is_uc;
      reset_req_o <= inj_valid_i && code_d == C_RST;
      if (cfg_we_i) begin
        case (cfg_sel_i)
          2'd0: if (cfg_bank_i < NB8) ctl_q[cb] <= cfg_data_i;
          2'd1: if (cfg_bank_i < NB8) st_q[cb] <= cfg_data_i;
          2'd2: gs_q <= cfg_data_i;
          default: ;
        endcase
      end
      if (inj_valid_i && code_d == C_LOG) begin
        st_q[ib] <= new_st;
        ad_q[ib] <= inj_addr_i;
        mi_q[ib] <= inj_misc_i;
        if (is_uc) gs_q <= inj_gstat_i;
      end
      if (inj_valid_i && code_d == C_OVF) st_q[ib][B_OVR] <= 1'b1;
    end
  end

  wire rd_ok = rd_bank_i < NB8;
  assign rd_ctl_o    = rd_ok ? ctl_q[rb] : '0;
  assign rd_status_o = rd_ok ? st_q[rb]  : '0;
  assign rd_addr_o   = rd_ok ? ad_q[rb]  : '0;
  assign rd_misc_o   = rd_ok ? mi_q[rb]  : '0;
  assign gstat_o     = gs_q;

  AST_IRQ_ON_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (out_valid_o && out_code_o == C_LOG && !reset_req_o)); // R6
  AST_RESET_ON_ESC: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> (out_valid_o && out_code_o == C_RST)); // R5
  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_code_o <= C_RST && !$past(cfg_we_i))
      |-> ($stable(st_q) && $stable(ad_q) && $stable(mi_q) && $stable(gs_q))); // R2
  AST_OVF_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_code_o == C_OVF) |-> ($stable(ad_q) && $stable(mi_q))); // R8
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ($past(inj_valid_i) && out_code_o <= C_OVF)); // R9
endmodule

// File: tb/sim_mce_bank_log.sv
module sim_mce_bank_log;
  localparam int CLK = 10;
  localparam logic [63:0] VAL = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OVR = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UC  = 64'h2000_0000_0000_0000;
  localparam logic [63:0] AR  = 64'h0080_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_n = 0;
  logic [15:0] cap_i = 16'h0104;
  logic [63:0] gctl_i = ONES;
  logic mce_en_i = 1;
  logic cfg_we_i = 0;
  logic [1:0] cfg_sel_i = 0;
  logic [7:0] cfg_bank_i = 0;
  logic [63:0] cfg_data_i = 0;
  logic inj_valid_i = 0;
  logic [7:0] inj_bank_i = 0;
  logic [63:0] inj_status_i = 0, inj_gstat_i = 0, inj_addr_i = 0, inj_misc_i = 0;
  logic inj_uncond_i = 0;
  logic [7:0] rd_bank_i = 0;
  logic [63:0] rd_ctl_o, rd_status_o, rd_addr_o, rd_misc_o, gstat_o;
  logic out_valid_o, irq_o, reset_req_o;
  logic [2:0] out_code_o;

  int errors = 0, checks = 0;
  bit done = 0;

  mce_bank_log u0 (.*);

  always #(CLK/2) clk = ~clk;

  logic [63:0] m_ctl [4];
  logic [63:0] m_st [4];
  logic [63:0] m_ad [4];
  logic [63:0] m_mi [4];
  logic [63:0] m_gs, m_os, m_ns;
  logic m_ov, m_irq, m_rr;
  logic [2:0] m_code, m_c;
  int m_b;

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6/R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ctl[i] = ONES; m_st[i] = 0; m_ad[i] = 0; m_mi[i] = 0;
    end
    m_gs = 0; m_ov = 0; m_code = 0; m_irq = 0; m_rr = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      m_b = int'(inj_bank_i);
      m_os = (m_b < 4) ? m_st[m_b] : 64'd0;
      if (cap_i == 0 || m_b >= int'(cap_i[7:0]) || m_b >= 4 || !inj_status_i[63]) m_c = 0;
      else if (!inj_uncond_i && !inj_status_i[55] && m_gs[2]) m_c = 1;
      else if (inj_status_i[61]) begin
        if ((cap_i[8] && gctl_i != ONES) || m_ctl[m_b] != ONES) m_c = 2;
        else if (!mce_en_i || m_gs[2]) m_c = 3;
        else m_c = 4;
      end else if (!m_os[63] || !m_os[61]) m_c = 4;
      else m_c = 5;
      m_ov = inj_valid_i;
      m_code = inj_valid_i ? m_c : 3'd0;
      m_irq = inj_valid_i && m_c == 4 && inj_status_i[61];
      m_rr = inj_valid_i && m_c == 3;
      if (cfg_we_i) begin
        if (cfg_sel_i == 0 && cfg_bank_i < 4) m_ctl[cfg_bank_i] = cfg_data_i;
        if (cfg_sel_i == 1 && cfg_bank_i < 4) m_st[cfg_bank_i] = cfg_data_i;
        if (cfg_sel_i == 2) m_gs = cfg_data_i;
      end
      if (inj_valid_i && m_c == 4) begin
        m_ns = inj_status_i | (m_os[63] ? OVR : 64'd0);
        m_st[m_b] = m_ns; m_ad[m_b] = inj_addr_i; m_mi[m_b] = inj_misc_i;
        if (inj_status_i[61]) m_gs = inj_gstat_i;
      end
      if (inj_valid_i && m_c == 5) m_st[m_b] = m_st[m_b] | OVR;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [63:0] ec, es, ea, em;
      ec = (rd_bank_i < 4) ? m_ctl[rd_bank_i] : 64'd0;
      es = (rd_bank_i < 4) ? m_st[rd_bank_i] : 64'd0;
      ea = (rd_bank_i < 4) ? m_ad[rd_bank_i] : 64'd0;
      em = (rd_bank_i < 4) ? m_mi[rd_bank_i] : 64'd0;
      checks++;
      if (out_valid_o !== m_ov || out_code_o !== m_code || irq_o !== m_irq ||
          reset_req_o !== m_rr || gstat_o !== m_gs || rd_ctl_o !== ec ||
          rd_status_o !== es || rd_addr_o !== ea || rd_misc_o !== em) begin
        errors++;
        $display("FAIL %s/R9/R10 model: got v=%0b c=%0d i=%0b r=%0b gs=%h st=%h ad=%h mi=%h ctl=%h exp v=%0b c=%0d i=%0b r=%0b gs=%h st=%h ad=%h mi=%h ctl=%h",
          tag_of(m_code), out_valid_o, out_code_o, irq_o, reset_req_o, gstat_o, rd_status_o,
          rd_addr_o, rd_misc_o, rd_ctl_o, m_ov, m_code, m_irq, m_rr, m_gs, es, ea, em, ec);
      end
    end
  end

  task automatic check64(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic inj(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                     input logic un, input logic [2:0] exp, input string tag);
    inj_valid_i = 1; inj_bank_i = b; inj_status_i = st; inj_gstat_i = gs;
    inj_addr_i = {st[31:0], 32'hA0A0_0000}; inj_misc_i = {32'h5E5E_0000, st[31:0]};
    inj_uncond_i = un;
    @(negedge clk);
    inj_valid_i = 0;
    #2;
    check64({tag, " code"}, {60'd0, out_valid_o, out_code_o}, {60'd0, 1'b1, exp});
    check64({tag, " pulses"}, {62'd0, irq_o, reset_req_o},
            {62'd0, (exp == 3'd4 && st[61]), exp == 3'd3});
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] b, input logic [63:0] d);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_bank_i = b; cfg_data_i = d;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic rd(input logic [7:0] b, input logic [63:0] exp, input string tag);
    rd_bank_i = b;
    #2;
    check64(tag, rd_status_o, exp);
  endtask

  initial begin
    #(CLK * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd_bank_i = 8'(i);
      #1;
      check64("R1 status", rd_status_o, 64'd0);
      check64("R1 ctl", rd_ctl_o, ONES);
    end
    check64("R1 gstat/out", {gstat_o[60:0], out_valid_o, irq_o, reset_req_o}, 64'd0);
    @(negedge clk);

    inj(0, VAL | UC | 64'h11, 64'h5, 0, 3'd4, "R6");
    check64("R9 out drops", {63'd0, out_valid_o}, 64'd0);
    rd(0, VAL | UC | 64'h11, "R6 status");
    check64("R6 gstat", gstat_o, 64'h5);
    inj(1, VAL | 64'h22, 0, 0, 3'd1, "R3 ignore");
    rd(1, 64'd0, "R3 untouched");
    inj(1, VAL | 64'h22, 0, 1, 3'd4, "R3 uncond");
    rd(1, VAL | 64'h22, "R7 status");
    inj(1, VAL | 64'h33, 0, 1, 3'd4, "R7 overwrite");
    rd(1, VAL | OVR | 64'h33, "R7 over");
    check64("R7 gstat kept", gstat_o, 64'h5);
    inj(0, VAL | 64'h44, 0, 1, 3'd5, "R8");
    rd(0, VAL | OVR | UC | 64'h11, "R8 over only");
    inj(2, VAL | UC | AR | 64'h55, 0, 0, 3'd3, "R5 in progress");
    rd(2, 64'd0, "R5 untouched");
    cfg(2, 0, 64'd0);
    check64("R10 gstat write", gstat_o, 64'd0);
    cfg(0, 2, 64'd0);
    rd_bank_i = 2; #1;
    check64("R10 ctl write", rd_ctl_o, 64'd0);
    inj(2, VAL | UC | 64'h66, 0, 0, 3'd2, "R4 bank ctl");
    rd(2, 64'd0, "R4 untouched");
    gctl_i = 0;
    inj(3, VAL | UC | 64'h77, 0, 0, 3'd2, "R4 global ctl");
    cap_i = 16'h0004;
    inj(3, VAL | UC | 64'h77, 0, 0, 3'd4, "R4 no ctl present");
    rd(3, VAL | UC | 64'h77, "R4 logged");
    gctl_i = ONES; cap_i = 16'h0104;
    mce_en_i = 0;
    inj(1, VAL | UC | 64'h88, 0, 0, 3'd3, "R5 disabled");
    mce_en_i = 1;
    inj(4, VAL | 64'h1, 0, 1, 3'd0, "R2 bank limit");
    cap_i = 16'h0102;
    inj(3, VAL | 64'h1, 0, 1, 3'd0, "R2 cap count");
    cap_i = 16'h0000;
    inj(0, VAL | 64'h1, 0, 1, 3'd0, "R2 cap zero");
    cap_i = 16'h0108;
    inj(5, VAL | 64'h1, 0, 1, 3'd0, "R2 beyond NB");
    cap_i = 16'h0104;
    inj(0, UC | 64'h99, 0, 1, 3'd0, "R2 no valid");
    rd(0, VAL | OVR | UC | 64'h11, "R2 untouched");
    cfg(1, 0, 64'hABC);
    rd(0, 64'hABC, "R10 status write");
    rd(7, 64'd0, "R10 out of range read");

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rd_bank_i = 8'($urandom_range(0, 5));
      cfg_we_i = 0; inj_valid_i = 0;
      if (n % 97 == 0) begin
        case ($urandom_range(0, 4))
          0: cap_i = 16'h0104;
          1: cap_i = 16'h0004;
          2: cap_i = 16'h0103;
          3: cap_i = 16'h0000;
          default: cap_i = 16'h0108;
        endcase
        gctl_i = ($urandom_range(0, 4) == 0) ? 64'd0 : ONES;
        mce_en_i = ($urandom_range(0, 9) != 0);
      end
      if (r < 45) begin
        inj_valid_i = 1;
        inj_bank_i = 8'($urandom_range(0, 5));
        inj_status_i = {$urandom, $urandom};
        inj_status_i[63] = ($urandom_range(0, 9) != 0);
        inj_gstat_i = {61'd0, 3'($urandom)};
        inj_addr_i = {$urandom, $urandom};
        inj_misc_i = {$urandom, $urandom};
        inj_uncond_i = 1'($urandom);
      end else if (r < 55) begin
        cfg_we_i = 1;
        cfg_sel_i = 2'($urandom_range(0, 2));
        cfg_bank_i = 8'($urandom_range(0, 4));
        cfg_data_i = (cfg_sel_i == 0) ? (($urandom_range(0, 3) == 0) ? 64'd0 : ONES) :
                     (cfg_sel_i == 1) ? 64'd0 : {61'd0, 3'($urandom)};
      end
      @(negedge clk);
    end
    inj_valid_i = 0; cfg_we_i = 0;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule